// File: doc/BRIEF.md
# User-Mode Memory Protection Checker

This block decides, within the same cycle, whether a memory access may proceed. It takes an access address, an access kind (instruction fetch, load or store) and a flag that says whether the requester runs in machine mode. Machine-mode accesses always pass. A user-mode access passes only when the address falls inside a configured region whose permission bit for that access kind is set. Otherwise the block denies the access and reports the matching access-fault cause code.

Regions are top-of-range windows. A fixed set of bound registers is laid out in ascending index order. Region k covers addresses from bound k-1 (or zero for region 0) up to, but not including, bound k. Each region has its own three-bit permission entry. All regions are compared in parallel. When regions overlap, the lowest-numbered match decides. Machine-mode software programs the bounds and permissions through a write-only register port. Each write takes effect at the next clock edge.

Top module: `upriv_guard`

## Requirements
- R1: After reset every bound register and every permission entry is zero, so every user-mode access is denied.
- R2: A write with `cfg_we`=1 updates an entry at the next rising clock edge. With `cfg_is_bound`=1, bound register `cfg_idx` takes the whole `cfg_wdata`. With `cfg_is_bound`=0, permission entry `cfg_idx` takes `cfg_wdata[2:0]`, with read at bit 0, write at bit 1 and execute at bit 2. Bits above bit 2 of a permission write are ignored.
- R3: Region k matches an address A when lo <= A < bound k (unsigned). For k>0, lo is bound k-1. For region 0, lo is zero. An address equal to bound k is outside region k, and a region whose lower bound is not below its upper bound matches nothing.
- R4: When several regions match, only the lowest-numbered one decides. Its missing permission denies the access even if a higher region would allow it.
- R5: A user-mode access that matches no region is denied.
- R6: When `chk_mach`=1 the access is allowed with cause 0, whatever the regions hold.
- R7: Access kind encodings are 0 = fetch (needs execute), 1 = load (needs read), and 2 or 3 = store (needs write).
- R8: On a deny, `chk_cause` is 1 for a fetch, 5 for a load and 7 for a store. On an allow, `chk_cause` is 0.
- R9: `chk_allow` and `chk_cause` follow `chk_addr`, `chk_kind` and `chk_mach` combinationally, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register port |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_is_bound | input | 1 | 1 selects a bound register, 0 selects a permission entry |
| cfg_idx | input | 2 | Entry index |
| cfg_wdata | input | 32 | Write data |
| chk_addr | input | 32 | Address under check |
| chk_kind | input | 2 | Access kind (see R7) |
| chk_mach | input | 1 | 1 when the requester runs in machine mode |
| chk_allow | output | 1 | 1 when the access may proceed |
| chk_cause | output | 4 | Access-fault cause on a deny, 0 otherwise |

## Verification
The hardest case to reach from the ports is overlap. A bound that is lower than its predecessor makes that region empty. It also pulls the next region's lower edge down into an earlier region's window. Only addresses in that shared slice show whether the lowest-index match wins. Directed writes build such a slice with a read-only low region over it, and stores into the slice must fault. The random phase draws bounds and addresses from a narrow 16-bit range, so overlaps and exact-bound hits happen often.

// File: rtl/pgd_pkg.sv
package pgd_pkg;
    typedef enum logic [1:0] {
        ACC_FETCH     = 2'd0,
        ACC_LOAD      = 2'd1,
        ACC_STORE     = 2'd2,
        ACC_STORE_ALT = 2'd3
    } acc_kind_e;

    localparam int PERM_W  = 3;
    localparam int PERM_R  = 0;
    localparam int PERM_WR = 1;
    localparam int PERM_X  = 2;

    localparam int CAUSE_W = 4;
    localparam logic [CAUSE_W-1:0] CAUSE_NONE  = 4'd0;
    localparam logic [CAUSE_W-1:0] CAUSE_FETCH = 4'd1;
    localparam logic [CAUSE_W-1:0] CAUSE_LOAD  = 4'd5;
    localparam logic [CAUSE_W-1:0] CAUSE_STORE = 4'd7;
endpackage

// File: rtl/pgd_regs.sv
module pgd_regs
    import pgd_pkg::*;
#(
    parameter int N_RGN  = 4,
    parameter int ADDR_W = 32,
    localparam int IDX_W = (N_RGN > 1) ? $clog2(N_RGN) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic                           is_bound,
    input  logic [IDX_W-1:0]               idx,
    input  logic [ADDR_W-1:0]              wdata,
    output logic [N_RGN-1:0][ADDR_W-1:0]   bounds,
    output logic [N_RGN-1:0][PERM_W-1:0]   perms
);
    for (genvar k = 0; k < N_RGN; k++) begin : g_ent
        logic hit_sel;
        assign hit_sel = we && (idx == IDX_W'(k));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bounds[k] <= '0;
                perms[k]  <= '0;
            end else if (hit_sel) begin
                if (is_bound) bounds[k] <= wdata;
                else          perms[k]  <= wdata[PERM_W-1:0];
            end
        end

        // R2: a bound write is visible after the next edge
        a_r2_bound_store: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(we) && $past(is_bound) && $past(idx) == IDX_W'(k))
                |-> bounds[k] == $past(wdata));
        // R2: a permission write keeps only the low three bits
        a_r2_perm_store: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(we) && !$past(is_bound) && $past(idx) == IDX_W'(k))
                |-> perms[k] == $past(wdata[PERM_W-1:0]));
    end
endmodule

// File: rtl/pgd_match.sv
module pgd_match
    import pgd_pkg::*;
#(
    parameter int N_RGN  = 4,
    parameter int ADDR_W = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [N_RGN-1:0][ADDR_W-1:0]   bounds,
    input  logic [N_RGN-1:0][PERM_W-1:0]   perms,
    input  logic [ADDR_W-1:0]              addr,
    output logic                           hit_any,
    output logic [PERM_W-1:0]              sel_perm
);
    logic [N_RGN-1:0] in_rng;
    logic [N_RGN-1:0] first_hit;

    for (genvar k = 0; k < N_RGN; k++) begin : g_cmp
        logic [ADDR_W-1:0] lo;
        if (k == 0) begin : g_base
            assign lo = '0;
        end else begin : g_prev
            assign lo = bounds[k-1];
        end
        assign in_rng[k] = (addr >= lo) && (addr < bounds[k]);
    end

    always_comb begin
        first_hit = '0;
        hit_any   = 1'b0;
        for (int k = 0; k < N_RGN; k++) begin
            if (in_rng[k] && !hit_any) begin
                first_hit[k] = 1'b1;
                hit_any      = 1'b1;
            end
        end
    end

    always_comb begin
        sel_perm = '0;
        for (int k = 0; k < N_RGN; k++) begin
            if (first_hit[k]) sel_perm = sel_perm | perms[k];
        end
    end

    // R4: at most one region is chosen
    a_r4_single_pick: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(first_hit));
    // R3: a chosen region must really contain the address
    a_r3_pick_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ((first_hit & ~in_rng) == '0));
endmodule

// File: rtl/upriv_guard.sv
module upriv_guard
    import pgd_pkg::*;
#(
    parameter int N_RGN  = 4,
    parameter int ADDR_W = 32,
    localparam int IDX_W = (N_RGN > 1) ? $clog2(N_RGN) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic               cfg_is_bound,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [ADDR_W-1:0]  cfg_wdata,
    input  logic [ADDR_W-1:0]  chk_addr,
    input  logic [1:0]         chk_kind,
    input  logic               chk_mach,
    output logic               chk_allow,
    output logic [CAUSE_W-1:0] chk_cause
);
    logic [N_RGN-1:0][ADDR_W-1:0] bounds;
    logic [N_RGN-1:0][PERM_W-1:0] perms;
    logic                         hit_any;
    logic [PERM_W-1:0]            sel_perm;
    logic                         need_ok;
    acc_kind_e                    kind;

    pgd_regs #(.N_RGN(N_RGN), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .is_bound(cfg_is_bound),
        .idx(cfg_idx), .wdata(cfg_wdata), .bounds(bounds), .perms(perms)
    );

    pgd_match #(.N_RGN(N_RGN), .ADDR_W(ADDR_W)) u_match (
        .clk(clk), .rst_n(rst_n), .bounds(bounds), .perms(perms),
        .addr(chk_addr), .hit_any(hit_any), .sel_perm(sel_perm)
    );

    assign kind = acc_kind_e'(chk_kind);

    always_comb begin
        unique case (kind)
            ACC_FETCH:                need_ok = sel_perm[PERM_X];
            ACC_LOAD:                 need_ok = sel_perm[PERM_R];
            ACC_STORE, ACC_STORE_ALT: need_ok = sel_perm[PERM_WR];
            default:                  need_ok = 1'b0;
        endcase
    end

    always_comb begin
        chk_allow = chk_mach || (hit_any && need_ok);
        if (chk_allow) begin
            chk_cause = CAUSE_NONE;
        end else begin
            unique case (kind)
                ACC_FETCH: chk_cause = CAUSE_FETCH;
                ACC_LOAD:  chk_cause = CAUSE_LOAD;
                default:   chk_cause = CAUSE_STORE;
            endcase
        end
    end

    a_r6_mach_pass: assert property (@(posedge clk) disable iff (!rst_n)
        chk_mach |-> chk_allow);
    a_r8_allow_no_cause: assert property (@(posedge clk) disable iff (!rst_n)
        chk_allow |-> chk_cause == CAUSE_NONE);
    a_r8_deny_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_allow |-> ((chk_kind == 2'd0 && chk_cause == CAUSE_FETCH) ||
                        (chk_kind == 2'd1 && chk_cause == CAUSE_LOAD) ||
                        (chk_kind[1] && chk_cause == CAUSE_STORE)));
    a_r5_no_match_deny: assert property (@(posedge clk) disable iff (!rst_n)
        (!chk_mach && !hit_any) |-> !chk_allow);
endmodule

// File: tb/sim_upriv_guard.sv
module sim_upriv_guard;
    localparam int N  = 4;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic          cfg_is_bound = 1'b0;
    logic [1:0]    cfg_idx = '0;
    logic [AW-1:0] cfg_wdata = '0;
    logic [AW-1:0] chk_addr = '0;
    logic [1:0]    chk_kind = '0;
    logic          chk_mach = 1'b0;
    logic          chk_allow;
    logic [3:0]    chk_cause;

    int n_checks = 0;
    int n_errors = 0;
    logic [AW-1:0] sh_bound [N];
    logic [2:0]    sh_perm  [N];

    always #4 clk = ~clk;

    upriv_guard u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_is_bound(cfg_is_bound),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .chk_addr(chk_addr),
        .chk_kind(chk_kind), .chk_mach(chk_mach), .chk_allow(chk_allow),
        .chk_cause(chk_cause)
    );

    function automatic logic [4:0] expect_of(logic [AW-1:0] a, logic [1:0] k, logic m);
        logic [2:0]    p;
        logic          found;
        logic          ok;
        logic [AW-1:0] lo;
        p = '0; found = 1'b0;
        for (int i = 0; i < N; i++) begin
            lo = (i == 0) ? '0 : sh_bound[i-1];
            if (!found && a >= lo && a < sh_bound[i]) begin
                found = 1'b1;
                p = sh_perm[i];
            end
        end
        ok = (k == 2'd0) ? p[2] : (k == 2'd1) ? p[0] : p[1];
        if (m || (found && ok)) return {1'b1, 4'd0};
        return {1'b0, (k == 2'd0) ? 4'd1 : (k == 2'd1) ? 4'd5 : 4'd7};
    endfunction

    task automatic write_reg(input logic b, input int i, input logic [AW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_is_bound = b; cfg_idx = 2'(i); cfg_wdata = d;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        if (b) sh_bound[i] = d;
        else   sh_perm[i]  = d[2:0];
    endtask

    task automatic probe(input logic [AW-1:0] a, input logic [1:0] k, input logic m,
                         input string req);
        logic [4:0] ex;
        chk_addr = a; chk_kind = k; chk_mach = m;
        #1;
        ex = expect_of(a, k, m);
        n_checks++;
        if ({chk_allow, chk_cause} !== ex) begin
            n_errors++;
            $display("FAIL %s addr=%h kind=%0d mach=%0d got allow=%0d cause=%0d exp allow=%0d cause=%0d",
                     req, a, k, m, chk_allow, chk_cause, ex[4], ex[3:0]);
        end
    endtask

    initial begin
        #200000;
        n_errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        for (int i = 0; i < N; i++) begin sh_bound[i] = '0; sh_perm[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state denies every user access
        probe(32'h0, 2'd0, 1'b0, "R1");
        probe(32'h1234, 2'd1, 1'b0, "R1");
        probe(32'hFFFF_FFFF, 2'd2, 1'b0, "R1");
        // R6: machine mode passes
        probe(32'h1234, 2'd2, 1'b1, "R6");

        // Overlap layout: region0 [0,0x1000) read, region1 empty, region2 [0x800,0x3000) all
        write_reg(1'b1, 0, 32'h1000);
        write_reg(1'b0, 0, 32'h0000_0001);
        write_reg(1'b1, 1, 32'h0800);
        write_reg(1'b0, 1, 32'h7);
        write_reg(1'b1, 2, 32'h3000);
        write_reg(1'b0, 2, 32'h7);
        @(negedge clk);
        probe(32'h0FFF, 2'd1, 1'b0, "R3");
        probe(32'h0FFF, 2'd0, 1'b0, "R7");
        probe(32'h0900, 2'd2, 1'b0, "R4");
        probe(32'h0900, 2'd3, 1'b0, "R7");
        probe(32'h1000, 2'd2, 1'b0, "R3");
        probe(32'h2FFF, 2'd0, 1'b0, "R3");
        probe(32'h3000, 2'd1, 1'b0, "R5");
        probe(32'h3000, 2'd1, 1'b1, "R6");
        // R2: high bits of a permission write are dropped (read only stays)
        write_reg(1'b0, 2, 32'hFFFF_FFF9);
        @(negedge clk);
        probe(32'h2000, 2'd2, 1'b0, "R2");
        probe(32'h2000, 2'd1, 1'b0, "R2");
        // R9: output follows a new address without any clock edge
        probe(32'h2000, 2'd1, 1'b0, "R9");
        probe(32'h5000, 2'd1, 1'b0, "R9");
        probe(32'h0010, 2'd0, 1'b0, "R8");

        // Random phase
        for (int it = 0; it < 600; it++) begin
            int r;
            r = $urandom_range(0, 9);
            if (r < 3) begin
                logic [AW-1:0] d;
                d = {16'h0, 16'($urandom)};
                if ($urandom_range(0, 15) == 0) d = $urandom;
                write_reg($urandom_range(0, 1) == 1, $urandom_range(0, N-1), d);
                @(negedge clk);
            end
            begin
                logic [AW-1:0] a;
                int pick;
                pick = $urandom_range(0, 3);
                if (pick == 0) a = sh_bound[$urandom_range(0, N-1)];
                else if (pick == 1) a = sh_bound[$urandom_range(0, N-1)] - 1;
                else a = {16'h0, 16'($urandom)};
                probe(a, 2'($urandom), $urandom_range(0, 7) == 0, "R3/R4/R7");
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule